// File: doc/BRIEF.md
# Stack Arithmetic Sequencer

This block carries out a zero-operand arithmetic instruction on the word stack in memory. When the core issues a start pulse, the block takes the current stack pointer and the operation select. It then reads the top word and the word below it into two private scratch registers and combines them as a sum or a difference. It writes the single result back as the new top of stack. The architectural register file is never used, so no general-purpose register changes.

The stack grows toward lower addresses. A pop reads at the pointer and then moves the pointer up by one. The push moves the pointer down by one and then writes. Over a whole instruction the pointer moves up by one. The block talks to a single-port word memory whose read data is valid in the same cycle as the address. A ready input stalls any memory step for as long as it is held low. The core keeps fetching stopped while `busy` is high. At the end the block returns the new pointer with a one-cycle write strobe.

Top module: `stack_alu_seq`

## Requirements
- R1: After reset, `busy`, `done`, `sp_we` and `mem_we` are all 0.
- R2: A `start` seen while idle raises `busy` in the next cycle. In that cycle the block reads the memory at the sampled `sp_i`.
- R3: The second read takes place at `sp_i + 1`.
- R4: The result is written in exactly one cycle. That write is at address `sp_i + 1`, and `mem_we` is high only while `busy` is high.
- R5: When `op_sub` = 0, the written word is the word read at `sp_i + 1` plus the word read at `sp_i`, wrapping modulo 2^16.
- R6: When `op_sub` = 1, the written word is the word read at `sp_i + 1` minus the word read at `sp_i` (the old top), wrapping modulo 2^16.
- R7: While `mem_ready` is 0, the sequence does not advance, and `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R8: With `mem_ready` held at 1, `done` rises in the 4th cycle after the start edge and lasts one cycle. `sp_we` is high in that cycle and `sp_o` equals `sp_i + 1`. `busy` is 0 in the following cycle.
- R9: A `start` that arrives while `busy` is high has no effect. A new `sp_i` or `op_sub` presented at that time also has no effect.
- R10: Pointer arithmetic wraps modulo 2^16. With `sp_i` = 0xFFFF, the second read and the write are at 0x0000, and `sp_o` = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one stack operation (sampled when idle) |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| sp_i | input | 16 | Current stack pointer from the core |
| mem_ready | input | 1 | Memory accepts this cycle's access; 0 stalls |
| mem_rdata | input | 16 | Read data, valid for the address in the same cycle |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Result word to write |
| mem_we | output | 1 | Write enable for the push |
| busy | output | 1 | Sequence in progress; core must not fetch |
| done | output | 1 | One-cycle completion pulse |
| sp_we | output | 1 | Strobe to update the core stack pointer |
| sp_o | output | 16 | New stack pointer value |

## Verification
Without stalls, the first read address appears one cycle after the start edge, and the second read appears two cycles after it. The write is three cycles after the start edge, and `done` with the new pointer is four cycles after it. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the start edge and checks each item at its own count. Under random stalls it checks only the final memory word and `sp_o` at the `done` pulse, with one exception: in directed stall windows it checks that the outputs do not change.

// File: rtl/stack_alu_seq_pkg.sv
package stack_alu_seq_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_POP1 = 3'd1,
        ST_POP2 = 3'd2,
        ST_PUSH = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   ptr;
        logic [DATA_W-1:0]   tmp_top;
        logic [DATA_W-1:0]   tmp_next;
        logic                is_sub;
    } seq_regs_t;

endpackage

// File: rtl/sas_combine.sv
module sas_combine #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] res
);
    // Subtraction as lhs + ~rhs + 1, sharing one adder
    logic [W-1:0] rhs_sel;
    always_comb begin
        rhs_sel = sub ? ~rhs : rhs;
        res     = lhs + rhs_sel + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/sas_ptr_step.sv
module sas_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    output logic [W-1:0] up,
    output logic [W-1:0] down
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    always_comb begin
        up   = ptr + ONE;
        down = ptr - ONE;
    end
endmodule

// File: rtl/stack_alu_seq.sv
module stack_alu_seq
    import stack_alu_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sub,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_o
);

    seq_regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] ptr_up, ptr_down;
    logic [DATA_W-1:0] result;

    sas_ptr_step #(.W(ADDR_W)) u_step (
        .ptr  (regs_q.ptr),
        .up   (ptr_up),
        .down (ptr_down)
    );

    // second-popped word is the left operand
    sas_combine #(.W(DATA_W)) u_combine (
        .lhs (regs_q.tmp_next),
        .rhs (regs_q.tmp_top),
        .sub (regs_q.is_sub),
        .res (result)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_IDLE: begin
                if (start) begin
                    regs_d.state  = ST_POP1;
                    regs_d.ptr    = sp_i;
                    regs_d.is_sub = op_sub;
                end
            end
            ST_POP1: begin
                if (mem_ready) begin
                    regs_d.tmp_top = mem_rdata;
                    regs_d.ptr     = ptr_up;
                    regs_d.state   = ST_POP2;
                end
            end
            ST_POP2: begin
                if (mem_ready) begin
                    regs_d.tmp_next = mem_rdata;
                    regs_d.ptr      = ptr_up;
                    regs_d.state    = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (mem_ready) begin
                    regs_d.ptr   = ptr_down;
                    regs_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                regs_d.state = ST_IDLE;
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, ptr: '0, tmp_top: '0,
                        tmp_next: '0, is_sub: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        mem_addr  = (regs_q.state == ST_PUSH) ? ptr_down : regs_q.ptr;
        mem_wdata = result;
        mem_we    = (regs_q.state == ST_PUSH);
        busy      = (regs_q.state != ST_IDLE);
        done      = (regs_q.state == ST_DONE);
        sp_we     = (regs_q.state == ST_DONE);
        sp_o      = regs_q.ptr;
    end

endmodule

// File: rtl/stack_alu_seq_chk.sv
module stack_alu_seq_chk
    import stack_alu_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              busy,
    input logic              done,
    input logic              sp_we
);

    p_we_inside_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sp_we);

    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !mem_ready) |=>
            ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_write_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> !mem_we);

endmodule

bind stack_alu_seq stack_alu_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .sp_we     (sp_we)
);

// File: tb/sim_stack_alu_seq.sv
`timescale 1ns/1ps
module sim_stack_alu_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sub = 1'b0;
    logic [15:0] sp_i = '0;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_rdata;
    logic [15:0] mem_addr, mem_wdata, sp_o;
    logic        mem_we, busy, done, sp_we;

    logic [15:0] mem [0:255];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;

    stack_alu_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .sp_i(sp_i),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
        .sp_we(sp_we), .sp_o(sp_o)
    );

    function automatic logic [15:0] exp_res(logic [15:0] top, logic [15:0] nxt, logic sub);
        return sub ? (nxt - top) : (nxt + top);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0: no stall, 1: random stall, 2: random stall + start/sp noise
    task automatic run_op(input logic [15:0] sp, input logic [15:0] top,
                          input logic [15:0] nxt, input logic sub, input int mode);
        logic [15:0] sp1;
        logic [15:0] want;
        int cyc;
        int writes;
        sp1  = sp + 16'd1;
        want = exp_res(top, nxt, sub);
        mem[sp[7:0]]  = top;
        mem[sp1[7:0]] = nxt;
        writes = 0;
        @(negedge clk);
        sp_i = sp; op_sub = sub; start = 1'b1; mem_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy === 1'b1, "R2 busy", {31'd0, busy}, 32'd1);
        chk(mem_addr === sp, "R2 first read addr", {16'd0, mem_addr}, {16'd0, sp});
        while (done !== 1'b1 && cyc < 200) begin
            if (mem_we === 1'b1) begin
                if (mem_ready) writes++;
                chk(mem_addr === sp1, "R4 write addr", {16'd0, mem_addr}, {16'd0, sp1});
                chk(mem_wdata === want, sub ? "R6 write data" : "R5 write data",
                    {16'd0, mem_wdata}, {16'd0, want});
            end
            if (mode == 0 && cyc == 2)
                chk(mem_addr === sp1, "R3 second read addr", {16'd0, mem_addr}, {16'd0, sp1});
            if (mode != 0) mem_ready = ($urandom % 3) != 0;
            if (mode == 2) begin
                start = $urandom % 2;
                sp_i = 16'($urandom);
                op_sub = $urandom % 2;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; mem_ready = 1'b1;
        chk(cyc < 200, "R8 watchdog", cyc, 200);
        if (mode == 0) chk(cyc == 4, "R8 latency", cyc, 4);
        chk(sp_we === 1'b1, "R8 sp_we", {31'd0, sp_we}, 32'd1);
        chk(sp_o === sp1, "R8 sp_o", {16'd0, sp_o}, {16'd0, sp1});
        chk(writes == 1, "R4 one write", writes, 1);
        chk(mem[sp1[7:0]] === want, sub ? "R6 result" : (mode == 2 ? "R9 result" : "R5 result"),
            {16'd0, mem[sp1[7:0]]}, {16'd0, want});
        chk(mem[sp[7:0]] === top, "R4 old top kept", {16'd0, mem[sp[7:0]]}, {16'd0, top});
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R8 idle after done", {30'd0, busy, done}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0 && sp_we === 1'b0,
            "R1 reset outputs", {28'd0, busy, done, mem_we, sp_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && mem_we === 1'b0, "R1 idle after reset", {30'd0, busy, mem_we}, 0);

        run_op(16'h0040, 16'h0003, 16'h0005, 1'b0, 0);    // R5
        run_op(16'h0040, 16'h0003, 16'h0005, 1'b1, 0);    // R6: 5-3
        run_op(16'h0050, 16'h0009, 16'h0002, 1'b1, 0);    // R6 negative wrap
        run_op(16'h0060, 16'hFFFF, 16'h0001, 1'b0, 0);    // R5 wrap
        run_op(16'h8000, 16'h7FFF, 16'h8000, 1'b1, 0);    // R6 overflow
        run_op(16'hFFFF, 16'h1234, 16'h1111, 1'b0, 0);    // R10 pointer wrap

        // R7 directed stall in first pop
        mem[8'h20] = 16'h0011; mem[8'h21] = 16'h0022;
        @(negedge clk);
        sp_i = 16'h0020; op_sub = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mem_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(mem_addr === 16'h0020 && busy === 1'b1 && mem_we === 1'b0 && done === 1'b0,
                "R7 stall hold", {16'd0, mem_addr}, 32'h20);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        chk(mem_addr === 16'h0021, "R7 resumes", {16'd0, mem_addr}, 32'h21);
        @(negedge clk);
        mem_ready = 1'b0;
        @(negedge clk);
        chk(mem_we === 1'b1 && mem_wdata === 16'h0033, "R7 push stalled", {16'd0, mem_wdata}, 32'h33);
        @(negedge clk);
        chk(mem_we === 1'b1 && mem_addr === 16'h0021, "R7 push held", {16'd0, mem_addr}, 32'h21);
        mem_ready = 1'b1;
        @(negedge clk);
        chk(done === 1'b1 && mem[8'h21] === 16'h0033, "R7 result", {16'd0, mem[8'h21]}, 32'h33);
        @(negedge clk);

        for (int n = 0; n < 40; n++) begin
            logic [15:0] spr;
            spr = 16'($urandom);
            run_op(spr, 16'($urandom), 16'($urandom), 1'($urandom), (n % 2) + 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule